// File: doc/BRIEF.md
# Expanded Memory Page Mapper

This block translates CPU addresses that fall inside the expanded-memory page frames into physical DRAM addresses. It holds thirty-two page entries. Entries 0 to 23 cover a run of 16 KB frames starting at 0x40000. Entries 24 to 31 cover a second run starting at 0xD0000. Each entry stores an 8-bit low page number, plus a high byte that carries two more page bits and a per-page enable in bit 7. A translated address is the 10-bit page number followed by the CPU offset within the 16 KB frame. This reaches any of 1024 physical pages.

Software programs the entries through three consecutive I/O ports. The first port is the low page byte of the selected entry, the second is its high byte, and the third is the index register. The index register picks the entry. When its bit 7 is set, the entry number steps forward after every high-byte write, so a whole table can be loaded as a stream. A configuration bit moves the three ports between two base addresses, and a second bit opens or closes the window. The memory side is purely combinational. A memory controller uses the hit and valid flags to redirect the access, or to suppress it when the page lies beyond installed memory.

Top module: `emsPageMapper`

## Requirements
- R1: While winEn is low, the three ports ignore writes and every read returns 0xFF.
- R2: With altBase low the ports sit at 0x208..0x20A. With altBase high they sit at 0x218..0x21A. Reads at the inactive base return 0xFF, writes there are ignored, and both bases reach the same index register and entries.
- R3: Port offset 0 reads and writes the low byte of the selected entry, offset 1 its full high byte, and offset 2 the index register. Index bits [4:0] select the entry.
- R4: A high-byte write with index bit 7 set advances index bits [4:0] by one, modulo 32, and leaves bits [7:5] unchanged. With bit 7 clear, and for low-byte writes, the index does not change.
- R5: After reset every low byte reads 0xFF, every high byte reads 0x03 with the enable clear, the index reads 0x00, and no address hits.
- R6: Frame number cpuAddr[23:14] values 16..39 select entries 0..23, and values 52..59 select entries 24..31. Any other address never hits.
- R7: pageHit is set only when mapEn is high and the selected entry's high-byte bit 7 is set. Without a hit, physAddr equals cpuAddr.
- R8: On a hit, physAddr is {high[1:0], low[7:0], cpuAddr[13:0]}.
- R9: physValid is set only on a hit whose 10-bit page number is below memTopPage; otherwise the access must read as all ones and drop writes.
- R10: pageHit, physValid and physAddr follow cpuAddr in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| winEn | input | 1 | Opens the I/O window |
| altBase | input | 1 | Selects the 0x218 base instead of 0x208 |
| mapEn | input | 1 | Global translation enable |
| ioAddr | input | 16 | I/O port address |
| ioWrEn | input | 1 | I/O write strobe |
| ioRdEn | input | 1 | I/O read strobe |
| ioWrData | input | 8 | I/O write data |
| ioRdData | output | 8 | I/O read data, 0xFF when not addressed |
| cpuAddr | input | 24 | CPU memory address |
| memTopPage | input | 11 | Installed memory size in 16 KB pages |
| pageHit | output | 1 | Address falls in an enabled page frame |
| physValid | output | 1 | Hit lies inside installed memory |
| physAddr | output | 24 | Translated address, or cpuAddr on a miss |

## Verification
Several properties are checked on every cycle. A closed window always reads 0xFF. The index steps or holds exactly as the write traffic dictates. A hit never appears without the global enable or outside the two frame runs. The frame offset always passes through, and physValid never claims a page at or above memTopPage. Only the bench's scenarios show the rest: which physical page a given entry yields, that the two bases reach the same storage, that the wrap from entry 31 keeps the upper index bits, and that the reset contents read back as stated.

// File: rtl/emsPkg.sv
package emsPkg;
  localparam int ENTRIES   = 32;
  localparam int SEL_W     = $clog2(ENTRIES);
  localparam int HIGH_BITS = 2;
  localparam int PAGE_W    = 8 + HIGH_BITS;
  localparam int EN_BIT    = 7;
  localparam int AUTO_BIT  = 7;

  typedef struct packed {
    logic             wrLow;
    logic             wrHigh;
    logic [SEL_W-1:0] entrySel;
    logic [7:0]       data;
  } emsStrobeT;
endpackage

// File: rtl/emsPortCtrl.sv
module emsPortCtrl
  import emsPkg::*;
#(
  parameter logic [15:0] IO_BASE_LO = 16'h0208,
  parameter logic [15:0] IO_BASE_HI = 16'h0218
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        winEn,
  input  logic        altBase,
  input  logic [15:0] ioAddr,
  input  logic        ioWrEn,
  input  logic        ioRdEn,
  input  logic [7:0]  ioWrData,
  input  logic [7:0]  selLow,
  input  logic [7:0]  selHigh,
  output emsStrobeT   strobe,
  output logic [7:0]  ioRdData,
  output logic [7:0]  indexReg
);
  logic [15:0] base;
  logic hitLow, hitHigh, hitIdx;

  assign base    = altBase ? IO_BASE_HI : IO_BASE_LO;
  assign hitLow  = winEn && (ioAddr == base);
  assign hitHigh = winEn && (ioAddr == base + 16'd1);
  assign hitIdx  = winEn && (ioAddr == base + 16'd2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      indexReg <= 8'h00;
    end else if (ioWrEn && hitIdx) begin
      indexReg <= ioWrData;
    end else if (ioWrEn && hitHigh && indexReg[AUTO_BIT]) begin
      indexReg[SEL_W-1:0] <= indexReg[SEL_W-1:0] + 1'b1;
    end
  end

  always_comb begin
    strobe.wrLow    = ioWrEn && hitLow;
    strobe.wrHigh   = ioWrEn && hitHigh;
    strobe.entrySel = indexReg[SEL_W-1:0];
    strobe.data     = ioWrData;
  end

  always_comb begin
    ioRdData = 8'hFF;
    if (ioRdEn) begin
      if (hitLow)       ioRdData = selLow;
      else if (hitHigh) ioRdData = selHigh;
      else if (hitIdx)  ioRdData = indexReg;
    end
  end
endmodule

// File: rtl/emsPageDatapath.sv
module emsPageDatapath
  import emsPkg::*;
#(
  parameter int CPU_ADDR_W       = 24,
  parameter int PAGE_SHIFT       = 14,
  parameter int LOW_FRAME_FIRST  = 16,
  parameter int LOW_FRAME_COUNT  = 24,
  parameter int HIGH_FRAME_FIRST = 52,
  localparam int PHYS_W          = PAGE_W + PAGE_SHIFT
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  emsStrobeT             strobe,
  input  logic                  mapEn,
  input  logic [CPU_ADDR_W-1:0] cpuAddr,
  input  logic [PAGE_W:0]       memTopPage,
  output logic [7:0]            selLow,
  output logic [7:0]            selHigh,
  output logic                  pageHit,
  output logic                  physValid,
  output logic [PHYS_W-1:0]     physAddr
);
  localparam int FRAME_W     = CPU_ADDR_W - PAGE_SHIFT;
  localparam int HIGH_COUNT  = ENTRIES - LOW_FRAME_COUNT;
  localparam logic [7:0] HIGH_RESET = 8'((1 << HIGH_BITS) - 1);

  logic [7:0] lowReg  [ENTRIES];
  logic [7:0] highReg [ENTRIES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        lowReg[e]  <= 8'hFF;
        highReg[e] <= HIGH_RESET;
      end
    end else begin
      if (strobe.wrLow)  lowReg[strobe.entrySel]  <= strobe.data;
      if (strobe.wrHigh) highReg[strobe.entrySel] <= strobe.data;
    end
  end

  assign selLow  = lowReg[strobe.entrySel];
  assign selHigh = highReg[strobe.entrySel];

  logic [FRAME_W-1:0] frame;
  logic               inLow, inHigh;
  logic [SEL_W-1:0]   entryIdx;
  logic [PAGE_W-1:0]  physPage;

  assign frame  = cpuAddr[CPU_ADDR_W-1:PAGE_SHIFT];
  assign inLow  = (frame >= FRAME_W'(LOW_FRAME_FIRST)) &&
                  (frame <  FRAME_W'(LOW_FRAME_FIRST + LOW_FRAME_COUNT));
  assign inHigh = (frame >= FRAME_W'(HIGH_FRAME_FIRST)) &&
                  (frame <  FRAME_W'(HIGH_FRAME_FIRST + HIGH_COUNT));

  always_comb begin
    if (inLow) entryIdx = SEL_W'(frame - FRAME_W'(LOW_FRAME_FIRST));
    else       entryIdx = SEL_W'(frame - FRAME_W'(HIGH_FRAME_FIRST) + FRAME_W'(LOW_FRAME_COUNT));
  end

  assign physPage  = {highReg[entryIdx][HIGH_BITS-1:0], lowReg[entryIdx]};
  assign pageHit   = mapEn && (inLow || inHigh) && highReg[entryIdx][EN_BIT];
  assign physValid = pageHit && ({1'b0, physPage} < memTopPage);
  assign physAddr  = pageHit ? {physPage, cpuAddr[PAGE_SHIFT-1:0]} : PHYS_W'(cpuAddr);
endmodule

// File: rtl/emsPageMapper.sv
module emsPageMapper
  import emsPkg::*;
#(
  parameter logic [15:0] IO_BASE_LO       = 16'h0208,
  parameter logic [15:0] IO_BASE_HI       = 16'h0218,
  parameter int          CPU_ADDR_W       = 24,
  parameter int          PAGE_SHIFT       = 14,
  parameter int          LOW_FRAME_FIRST  = 16,
  parameter int          LOW_FRAME_COUNT  = 24,
  parameter int          HIGH_FRAME_FIRST = 52,
  localparam int         PHYS_W           = PAGE_W + PAGE_SHIFT
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  winEn,
  input  logic                  altBase,
  input  logic                  mapEn,
  input  logic [15:0]           ioAddr,
  input  logic                  ioWrEn,
  input  logic                  ioRdEn,
  input  logic [7:0]            ioWrData,
  output logic [7:0]            ioRdData,
  input  logic [CPU_ADDR_W-1:0] cpuAddr,
  input  logic [PAGE_W:0]       memTopPage,
  output logic                  pageHit,
  output logic                  physValid,
  output logic [PHYS_W-1:0]     physAddr
);
  emsStrobeT  strobe;
  logic [7:0] selLow, selHigh, indexReg;

  emsPortCtrl #(.IO_BASE_LO(IO_BASE_LO), .IO_BASE_HI(IO_BASE_HI)) u_ctrl (
    .clk(clk), .rstN(rstN), .winEn(winEn), .altBase(altBase),
    .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn), .ioWrData(ioWrData),
    .selLow(selLow), .selHigh(selHigh), .strobe(strobe),
    .ioRdData(ioRdData), .indexReg(indexReg)
  );

  emsPageDatapath #(
    .CPU_ADDR_W(CPU_ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
    .LOW_FRAME_FIRST(LOW_FRAME_FIRST), .LOW_FRAME_COUNT(LOW_FRAME_COUNT),
    .HIGH_FRAME_FIRST(HIGH_FRAME_FIRST)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mapEn(mapEn),
    .cpuAddr(cpuAddr), .memTopPage(memTopPage),
    .selLow(selLow), .selHigh(selHigh),
    .pageHit(pageHit), .physValid(physValid), .physAddr(physAddr)
  );
endmodule

// File: rtl/emsMapperChecker.sv
module emsMapperChecker
  import emsPkg::*;
#(
  parameter logic [15:0] IO_BASE_LO       = 16'h0208,
  parameter logic [15:0] IO_BASE_HI       = 16'h0218,
  parameter int          CPU_ADDR_W       = 24,
  parameter int          PAGE_SHIFT       = 14,
  parameter int          LOW_FRAME_FIRST  = 16,
  parameter int          LOW_FRAME_COUNT  = 24,
  parameter int          HIGH_FRAME_FIRST = 52,
  localparam int         PHYS_W           = PAGE_W + PAGE_SHIFT
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  winEn,
  input logic                  altBase,
  input logic                  mapEn,
  input logic [15:0]           ioAddr,
  input logic                  ioWrEn,
  input logic [7:0]            ioRdData,
  input logic [7:0]            indexReg,
  input logic [CPU_ADDR_W-1:0] cpuAddr,
  input logic [PAGE_W:0]       memTopPage,
  input logic                  pageHit,
  input logic                  physValid,
  input logic [PHYS_W-1:0]     physAddr
);
  localparam int FRAME_W = CPU_ADDR_W - PAGE_SHIFT;
  localparam int HIGH_COUNT = ENTRIES - LOW_FRAME_COUNT;

  logic [15:0] chkBase;
  logic        highWrite;
  logic [FRAME_W-1:0] chkFrame;
  logic        frameOk;

  assign chkBase   = altBase ? IO_BASE_HI : IO_BASE_LO;
  assign highWrite = ioWrEn && winEn && (ioAddr == chkBase + 16'd1);
  assign chkFrame  = cpuAddr[CPU_ADDR_W-1:PAGE_SHIFT];
  assign frameOk   = ((chkFrame >= FRAME_W'(LOW_FRAME_FIRST)) &&
                      (chkFrame <  FRAME_W'(LOW_FRAME_FIRST + LOW_FRAME_COUNT))) ||
                     ((chkFrame >= FRAME_W'(HIGH_FRAME_FIRST)) &&
                      (chkFrame <  FRAME_W'(HIGH_FRAME_FIRST + HIGH_COUNT)));

  assert_closed_window_R1: assert property (@(posedge clk) disable iff (!rstN)
    !winEn |-> ioRdData == 8'hFF);

  assert_index_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (highWrite && indexReg[AUTO_BIT]) |=>
      (indexReg[SEL_W-1:0] == SEL_W'($past(indexReg[SEL_W-1:0]) + 1'b1)) &&
      (indexReg[7:SEL_W] == $past(indexReg[7:SEL_W])));

  assert_index_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !ioWrEn |=> $stable(indexReg));

  assert_frame_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    pageHit |-> frameOk);

  assert_global_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    pageHit |-> mapEn);

  assert_offset_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    pageHit |-> physAddr[PAGE_SHIFT-1:0] == cpuAddr[PAGE_SHIFT-1:0]);

  assert_installed_limit_R9: assert property (@(posedge clk) disable iff (!rstN)
    physValid |-> (pageHit && ({1'b0, physAddr[PHYS_W-1:PAGE_SHIFT]} < memTopPage)));
endmodule

bind emsPageMapper emsMapperChecker #(
  .IO_BASE_LO(IO_BASE_LO), .IO_BASE_HI(IO_BASE_HI),
  .CPU_ADDR_W(CPU_ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
  .LOW_FRAME_FIRST(LOW_FRAME_FIRST), .LOW_FRAME_COUNT(LOW_FRAME_COUNT),
  .HIGH_FRAME_FIRST(HIGH_FRAME_FIRST)
) u_chk (
  .clk(clk), .rstN(rstN), .winEn(winEn), .altBase(altBase), .mapEn(mapEn),
  .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioRdData(ioRdData), .indexReg(indexReg),
  .cpuAddr(cpuAddr), .memTopPage(memTopPage), .pageHit(pageHit),
  .physValid(physValid), .physAddr(physAddr)
);

// File: tb/emsPageMapper_tb.sv
module emsPageMapper_tb;
  logic        clk = 1'b0;
  logic        rstN, winEn, altBase, mapEn, ioWrEn, ioRdEn;
  logic [15:0] ioAddr;
  logic [7:0]  ioWrData, ioRdData;
  logic [23:0] cpuAddr, physAddr;
  logic [10:0] memTopPage;
  logic        pageHit, physValid;

  int checks = 0;
  int errors = 0;
  int refLow[32];
  int refHigh[32];
  int refIdx;
  bit running = 0;

  always #10 clk = ~clk;

  emsPageMapper u_dut (
    .clk(clk), .rstN(rstN), .winEn(winEn), .altBase(altBase), .mapEn(mapEn),
    .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn), .ioWrData(ioWrData),
    .ioRdData(ioRdData), .cpuAddr(cpuAddr), .memTopPage(memTopPage),
    .pageHit(pageHit), .physValid(physValid), .physAddr(physAddr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [25:0] refMap(logic [23:0] c);
    int frame = int'(c >> 14);
    int idx = -1;
    int page;
    logic [23:0] phys;
    if (frame >= 16 && frame < 40) idx = frame - 16;
    else if (frame >= 52 && frame < 60) idx = frame - 28;
    if (!mapEn || idx < 0) return {2'b00, c};
    if ((refHigh[idx] & 'h80) == 0) return {2'b00, c};
    page = ((refHigh[idx] & 3) << 8) | refLow[idx];
    phys = 24'((page << 14) | (int'(c) & 'h3fff));
    return {1'b1, (page < int'(memTopPage)), phys};
  endfunction

  task automatic ioWrite(int addr, int data);
    int b;
    @(negedge clk);
    ioAddr = addr[15:0]; ioWrData = data[7:0]; ioWrEn = 1'b1;
    @(posedge clk);
    #1;
    b = altBase ? 'h218 : 'h208;
    if (winEn) begin
      if (addr == b) refLow[refIdx & 31] = data;
      else if (addr == b + 1) begin
        refHigh[refIdx & 31] = data;
        if ((refIdx & 'h80) != 0) refIdx = (refIdx & 'hE0) | ((refIdx + 1) & 31);
      end else if (addr == b + 2) refIdx = data;
    end
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic ioRead(int addr, int exp, string req);
    @(negedge clk);
    ioAddr = addr[15:0]; ioRdEn = 1'b1;
    #2;
    check(req, 32'(ioRdData), 32'(exp));
    ioRdEn = 1'b0;
  endtask

  task automatic memCheck(logic [23:0] c, logic [25:0] exp, string req);
    @(negedge clk);
    cpuAddr = c;
    #2;
    check(req, {6'd0, pageHit, physValid, physAddr}, {6'd0, exp});
  endtask

  // cycle-by-cycle comparison against the behavioural model (R8)
  always @(posedge clk) begin
    if (running) begin
      #15;
      if (running) check("R8 model", {6'd0, pageHit, physValid, physAddr}, {6'd0, refMap(cpuAddr)});
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; winEn = 0; altBase = 0; mapEn = 0; ioWrEn = 0; ioRdEn = 0;
    ioAddr = 0; ioWrData = 0; cpuAddr = 0; memTopPage = 11'h100;
    for (int i = 0; i < 32; i++) begin refLow[i] = 'hFF; refHigh[i] = 'h03; end
    refIdx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1; running = 1;

    // R5 reset state
    winEn = 1;
    ioRead('h208, 'hFF, "R5 low");
    ioRead('h209, 'h03, "R5 high");
    ioRead('h20A, 'h00, "R5 index");
    mapEn = 1;
    memCheck(24'h040000, {2'b00, 24'h040000}, "R5 nohit");

    // R1 closed window
    winEn = 0;
    ioWrite('h20A, 'h05);
    ioRead('h20A, 'hFF, "R1 closed read");
    winEn = 1;
    ioRead('h20A, 'h00, "R1 write ignored");

    // R3/R4 streamed load
    ioWrite('h20A, 'h80);
    ioWrite('h208, 'h12);
    ioWrite('h209, 'h81);
    ioRead('h20A, 'h81, "R4 step");
    ioWrite('h208, 'h34);
    ioRead('h20A, 'h81, "R4 low write holds");
    ioWrite('h209, 'h80);
    ioRead('h20A, 'h82, "R4 step2");
    ioWrite('h20A, 'h81);
    ioRead('h208, 'h34, "R3 low");
    ioRead('h209, 'h80, "R3 high");

    // R4 wrap keeps upper bits
    ioWrite('h20A, 'hBF);
    ioWrite('h208, 'h56);
    ioWrite('h209, 'h82);
    ioRead('h20A, 'hA0, "R4 wrap");

    // R4 no auto step
    ioWrite('h20A, 'h02);
    ioWrite('h209, 'h03);
    ioRead('h20A, 'h02, "R4 manual");

    // R2 alternate base
    altBase = 1;
    ioRead('h208, 'hFF, "R2 old base");
    ioRead('h21A, 'h02, "R2 shared index");
    ioWrite('h21A, 'h17);
    ioWrite('h218, 'h01);
    ioWrite('h219, 'h80);
    ioWrite('h208, 'h99);
    ioWrite('h20A, 'h00);
    ioRead('h21A, 'h17, "R2 index");
    ioRead('h218, 'h01, "R2 low");
    altBase = 0;
    ioRead('h20A, 'h17, "R2 back");
    ioRead('h209, 'h80, "R2 high");

    // memory side
    mapEn = 0;
    memCheck(24'h040123, {2'b00, 24'h040123}, "R7 global off");
    mapEn = 1;
    memCheck(24'h040123, {2'b10, 24'h448123}, "R9 beyond top");
    memCheck(24'h044567, {2'b11, 24'h0D0567}, "R8 entry1");
    memCheck(24'h09C004, {2'b11, 24'h004004}, "R6 entry23");
    memCheck(24'h0EC010, {2'b10, 24'h958010}, "R9 entry31 small");
    memTopPage = 11'h400;
    memCheck(24'h0EC010, {2'b11, 24'h958010}, "R10 entry31");
    memCheck(24'h048000, {2'b00, 24'h048000}, "R7 page off");
    memCheck(24'h0A0000, {2'b00, 24'h0A0000}, "R6 gap");
    memCheck(24'h0CC000, {2'b00, 24'h0CC000}, "R6 below high run");
    memCheck(24'h0F0000, {2'b00, 24'h0F0000}, "R6 above");
    memCheck(24'h03C000, {2'b00, 24'h03C000}, "R6 below");
    memCheck(24'h140123, {2'b00, 24'h140123}, "R6 alias");

    @(negedge clk);
    running = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule